// File: doc/BRIEF.md
# Panel Scan Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes, together with the current active-area pixel coordinates, for a parallel RGB panel. The panel timing is set by porch, sync-width and active-size fields. Every size field holds its count less one. A pixel-clock enable is produced from the source clock by an optional integer divider, and the scan only advances on that enable.

Software drives a set of staged configuration inputs. Each staged field is copied into a shadow bank, and only the shadow bank steers the scan. While the scan is running, the copy happens only at the frame boundary. A hold input defers the copy, so a multi-field update is never applied half-written. A frame interrupt is raised when vertical sync begins. Its pending bit is acknowledged with a one-cycle write-1 pulse. The interrupt enables act at once and are not shadowed.

Top module: `lcd_tgen`

## Requirements
- R1: A line lasts (cfg_hsw+1)+(cfg_hbp+1)+(cfg_hact+1)+(cfg_hfp+1) pixel ticks, in the order sync, back porch, active, front porch. Horizontal sync is active for the first cfg_hsw+1 ticks of every line.
- R2: A frame lasts (cfg_vsw+1)+(cfg_vbp+1)+(cfg_vact+1)+(cfg_vfp+1) lines, in the same order. The line count advances at the last tick of each line. Vertical sync is active for the first cfg_vsw+1 lines.
- R3: `de` is active-high. It is high only where both the horizontal and the vertical position lie in their active regions. While `de` is high, `pix_x`/`pix_y` give the 0-based position inside the active area; while `de` is low, both are 0.
- R4: With cfg_div_on=0, `pix_ce` is high on every clock of a running scan. With cfg_div_on=1, `pix_ce` is high once every cfg_div_m1+1 clocks. The scan position moves only on `pix_ce`.
- R5: A polarity bit of 0 makes its sync output active-high; a bit of 1 makes it active-low. cfg_hs_low sets the polarity of `hsync` and cfg_vs_low sets the polarity of `vsync`.
- R6: While the shadowed enable is 0, the scan rests at its first position. `hsync` and `vsync` sit at their inactive level, and `de`, `pix_ce`, `pix_x` and `pix_y` are 0. Once a 1 is loaded, the next clock shows the first sync pixel of a new frame.
- R7: Every cfg_* input except cfg_hold is staged. While the scan runs, the staged values are copied to the shadow bank on the clock edge that ends the last pixel tick of a frame, and the new frame uses them. While the scan is stopped, the copy is made on every clock edge.
- R8: While cfg_hold is 1, no copy takes place. After cfg_hold falls, the copy waits for the next opportunity defined in R7.
- R9: `int_pend` becomes 1 on the same clock edge on which vertical sync of a new frame begins, whatever the enable settings. `irq` = int_pend AND int_en AND int_frame_en.
- R10: An int_ack pulse clears `int_pend` at that clock edge. If a frame starts on the same edge, the set takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | Staged video enable |
| cfg_hs_low | input | 1 | Staged hsync polarity (1 = active low) |
| cfg_vs_low | input | 1 | Staged vsync polarity (1 = active low) |
| cfg_div_on | input | 1 | Staged divider enable |
| cfg_div_m1 | input | DIV_W | Staged divide factor minus one |
| cfg_hsw | input | H_W | Staged hsync width minus one |
| cfg_hbp | input | H_W | Staged horizontal back porch minus one |
| cfg_hact | input | H_W | Staged active width minus one |
| cfg_hfp | input | H_W | Staged horizontal front porch minus one |
| cfg_vsw | input | V_W | Staged vsync width minus one |
| cfg_vbp | input | V_W | Staged vertical back porch minus one |
| cfg_vact | input | V_W | Staged active height minus one |
| cfg_vfp | input | V_W | Staged vertical front porch minus one |
| cfg_hold | input | 1 | Defers the shadow copy while high |
| int_en | input | 1 | Global interrupt enable |
| int_frame_en | input | 1 | Frame interrupt enable |
| int_ack | input | 1 | Write-1 pulse that clears the pending bit |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_ce | output | 1 | Pixel tick |
| pix_x | output | H_W | Active-area column |
| pix_y | output | V_W | Active-area row |
| int_pend | output | 1 | Frame interrupt pending |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with H_W=6, V_W=5 and DIV_W=3. With these widths an all-ones sync width and the largest divide factor still give frames of only a few thousand clocks. Small random porch and active sizes keep most frames to tens or hundreds of clocks, so one run crosses many frame boundaries. That brings within reach hold windows that straddle a boundary, enables dropped and restored at a frame end, and acknowledge pulses that collide with a frame start.

// File: rtl/lcd_tgen_pkg.sv
package lcd_tgen_pkg;

    // Scan segment order within a line or a frame; the sequence is behaviour.
    typedef enum logic [1:0] {
        SEG_SYNC  = 2'd0,
        SEG_BACK  = 2'd1,
        SEG_ACT   = 2'd2,
        SEG_FRONT = 2'd3
    } seg_e;

    function automatic seg_e seg_next(input seg_e s);
        case (s)
            SEG_SYNC:  return SEG_BACK;
            SEG_BACK:  return SEG_ACT;
            SEG_ACT:   return SEG_FRONT;
            default:   return SEG_SYNC;
        endcase
    endfunction

endpackage

// File: rtl/lcd_tgen_axis.sv
// One scan axis: walks sync, back porch, active, front porch segments.
module lcd_tgen_axis
    import lcd_tgen_pkg::*;
#(
    parameter int W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_i,
    input  logic                step_i,
    input  logic [3:0][W-1:0]   len_i,   // indexed by seg_e, each count minus one
    output seg_e                seg_o,
    output logic [W-1:0]        cnt_o,
    output logic                last_o
);
    typedef struct packed {
        seg_e         seg;
        logic [W-1:0] cnt;
    } axis_t;

    axis_t st_d, st_q;
    logic  seg_done;

    always_comb begin
        seg_done = (st_q.cnt == len_i[st_q.seg]);
        st_d     = st_q;
        if (!run_i) begin
            st_d.seg = SEG_SYNC;
            st_d.cnt = '0;
        end else if (step_i) begin
            if (seg_done) begin
                st_d.cnt = '0;
                st_d.seg = seg_next(st_q.seg);
            end else begin
                st_d.cnt = st_q.cnt + W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{seg: SEG_SYNC, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign seg_o  = st_q.seg;
    assign cnt_o  = st_q.cnt;
    assign last_o = (st_q.seg == SEG_FRONT) && seg_done;
endmodule

// File: rtl/lcd_tgen_clkdiv.sv
// Pixel tick from the source clock, optional divide by div_m1_i+1.
module lcd_tgen_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             div_on_i,
    input  logic [DIV_W-1:0] div_m1_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_t;

    div_t st_d, st_q;
    logic wrap;

    always_comb begin
        wrap   = (st_q.cnt == div_m1_i);
        tick_o = run_i && (!div_on_i || wrap);
        st_d   = st_q;
        if (!run_i || !div_on_i || wrap) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/lcd_tgen_shadow.sv
// Shadow bank: copies the staged word when load_i is high.
module lcd_tgen_shadow #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] stg_i,
    output logic [W-1:0] sh_o
);
    typedef struct packed {
        logic [W-1:0] word;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.word = stg_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{word: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sh_o = st_q.word;
endmodule

// File: rtl/lcd_tgen_irq.sv
// Frame interrupt pending bit; set has priority over the write-1 clear.
module lcd_tgen_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start_i,
    input  logic ack_i,
    input  logic glb_en_i,
    input  logic frm_en_i,
    output logic pend_o,
    output logic irq_o
);
    typedef struct packed {
        logic pend;
    } irq_t;

    irq_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_start_i) begin
            st_d.pend = 1'b1;
        end else if (ack_i) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{pend: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign irq_o  = st_q.pend && glb_en_i && frm_en_i;
endmodule

// File: rtl/lcd_tgen.sv
module lcd_tgen
    import lcd_tgen_pkg::*;
#(
    parameter int H_W   = 12,
    parameter int V_W   = 11,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_hs_low,
    input  logic             cfg_vs_low,
    input  logic             cfg_div_on,
    input  logic [DIV_W-1:0] cfg_div_m1,
    input  logic [H_W-1:0]   cfg_hsw,
    input  logic [H_W-1:0]   cfg_hbp,
    input  logic [H_W-1:0]   cfg_hact,
    input  logic [H_W-1:0]   cfg_hfp,
    input  logic [V_W-1:0]   cfg_vsw,
    input  logic [V_W-1:0]   cfg_vbp,
    input  logic [V_W-1:0]   cfg_vact,
    input  logic [V_W-1:0]   cfg_vfp,
    input  logic             cfg_hold,
    input  logic             int_en,
    input  logic             int_frame_en,
    input  logic             int_ack,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic             pix_ce,
    output logic [H_W-1:0]   pix_x,
    output logic [V_W-1:0]   pix_y,
    output logic             int_pend,
    output logic             irq
);
    localparam int CFG_W = 4 + DIV_W + 4 * H_W + 4 * V_W;

    typedef struct packed {
        logic             en;
        logic             hs_low;
        logic             vs_low;
        logic             div_on;
        logic [DIV_W-1:0] div_m1;
        logic [H_W-1:0]   hsw;
        logic [H_W-1:0]   hbp;
        logic [H_W-1:0]   hact;
        logic [H_W-1:0]   hfp;
        logic [V_W-1:0]   vsw;
        logic [V_W-1:0]   vbp;
        logic [V_W-1:0]   vact;
        logic [V_W-1:0]   vfp;
    } cfg_t;

    cfg_t             stg;
    cfg_t             sh;
    logic [CFG_W-1:0] sh_vec;
    logic             run;
    logic             tick;
    logic             h_last, v_last;
    logic             frame_end;
    logic             load;
    logic             next_run;
    logic             frame_start;
    logic             hs_act, vs_act;
    seg_e             h_seg, v_seg;
    logic [H_W-1:0]   h_cnt;
    logic [V_W-1:0]   v_cnt;
    logic [3:0][H_W-1:0] h_len;
    logic [3:0][V_W-1:0] v_len;

    assign stg = '{en: cfg_en, hs_low: cfg_hs_low, vs_low: cfg_vs_low,
                   div_on: cfg_div_on, div_m1: cfg_div_m1,
                   hsw: cfg_hsw, hbp: cfg_hbp, hact: cfg_hact, hfp: cfg_hfp,
                   vsw: cfg_vsw, vbp: cfg_vbp, vact: cfg_vact, vfp: cfg_vfp};

    lcd_tgen_shadow #(.W(CFG_W)) u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .stg_i  (stg),
        .sh_o   (sh_vec)
    );

    assign sh  = cfg_t'(sh_vec);
    assign run = sh.en;

    lcd_tgen_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .div_on_i (sh.div_on),
        .div_m1_i (sh.div_m1),
        .tick_o   (tick)
    );

    // Segment lengths ordered by seg_e: sync, back, active, front.
    assign h_len = {sh.hfp, sh.hact, sh.hbp, sh.hsw};
    assign v_len = {sh.vfp, sh.vact, sh.vbp, sh.vsw};

    lcd_tgen_axis #(.W(H_W)) u_hax (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .step_i (tick),
        .len_i  (h_len),
        .seg_o  (h_seg),
        .cnt_o  (h_cnt),
        .last_o (h_last)
    );

    lcd_tgen_axis #(.W(V_W)) u_vax (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .step_i (tick && h_last),
        .len_i  (v_len),
        .seg_o  (v_seg),
        .cnt_o  (v_cnt),
        .last_o (v_last)
    );

    always_comb begin
        frame_end   = tick && h_last && v_last;
        load        = !cfg_hold && (!run || frame_end);
        next_run    = load ? stg.en : run;
        frame_start = next_run && (!run || frame_end);
        hs_act      = run && (h_seg == SEG_SYNC);
        vs_act      = run && (v_seg == SEG_SYNC);
        de          = run && (h_seg == SEG_ACT) && (v_seg == SEG_ACT);
        hsync       = hs_act ^ sh.hs_low;
        vsync       = vs_act ^ sh.vs_low;
        pix_x       = de ? h_cnt : '0;
        pix_y       = de ? v_cnt : '0;
        pix_ce      = tick;
    end

    lcd_tgen_irq u_irq (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_start_i (frame_start),
        .ack_i         (int_ack),
        .glb_en_i      (int_en),
        .frm_en_i      (int_frame_en),
        .pend_o        (int_pend),
        .irq_o         (irq)
    );
endmodule

// File: rtl/lcd_tgen_chk.sv
module lcd_tgen_chk #(
    parameter int H_W   = 12,
    parameter int V_W   = 11,
    parameter int CFG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run_i,
    input logic             hold_i,
    input logic [CFG_W-1:0] sh_vec_i,
    input logic             hs_low_i,
    input logic             vs_low_i,
    input logic             div_on_i,
    input logic             hsync_i,
    input logic             vsync_i,
    input logic             hs_act_i,
    input logic             vs_act_i,
    input logic             de_i,
    input logic             ce_i,
    input logic [H_W-1:0]   x_i,
    input logic [V_W-1:0]   y_i,
    input logic             frame_start_i,
    input logic             ack_i,
    input logic             pend_i,
    input logic             irq_i
);
    p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> (!de_i && !ce_i && hsync_i == hs_low_i && vsync_i == vs_low_i));

    p_coord_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !de_i |-> (x_i == '0 && y_i == '0));

    p_no_de_in_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_act_i || vs_act_i) |-> !de_i);

    p_ce_full_rate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !div_on_i) |-> ce_i);

    p_hold_freezes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> $stable(sh_vec_i));

    p_pend_at_vsync_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vs_act_i) |-> pend_i);

    p_irq_needs_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_i |-> pend_i);

    p_ack_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !frame_start_i) |=> !pend_i);
endmodule

bind lcd_tgen lcd_tgen_chk #(.H_W(H_W), .V_W(V_W), .CFG_W(CFG_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .run_i         (run),
    .hold_i        (cfg_hold),
    .sh_vec_i      (sh_vec),
    .hs_low_i      (sh.hs_low),
    .vs_low_i      (sh.vs_low),
    .div_on_i      (sh.div_on),
    .hsync_i       (hsync),
    .vsync_i       (vsync),
    .hs_act_i      (hs_act),
    .vs_act_i      (vs_act),
    .de_i          (de),
    .ce_i          (pix_ce),
    .x_i           (pix_x),
    .y_i           (pix_y),
    .frame_start_i (frame_start),
    .ack_i         (int_ack),
    .pend_i        (int_pend),
    .irq_i         (irq)
);

// File: tb/sim_lcd_tgen.sv
`timescale 1ns/1ps
module sim_lcd_tgen;
    localparam int H_W   = 6;
    localparam int V_W   = 5;
    localparam int DIV_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic             cfg_en = 0, cfg_hs_low = 0, cfg_vs_low = 0, cfg_div_on = 0;
    logic [DIV_W-1:0] cfg_div_m1 = '0;
    logic [H_W-1:0]   cfg_hsw = '0, cfg_hbp = '0, cfg_hact = '0, cfg_hfp = '0;
    logic [V_W-1:0]   cfg_vsw = '0, cfg_vbp = '0, cfg_vact = '0, cfg_vfp = '0;
    logic             cfg_hold = 0, int_en = 0, int_frame_en = 0, int_ack = 0;
    logic             hsync, vsync, de, pix_ce, int_pend, irq;
    logic [H_W-1:0]   pix_x;
    logic [V_W-1:0]   pix_y;

    lcd_tgen #(.H_W(H_W), .V_W(V_W), .DIV_W(DIV_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_en(cfg_en), .cfg_hs_low(cfg_hs_low), .cfg_vs_low(cfg_vs_low),
        .cfg_div_on(cfg_div_on), .cfg_div_m1(cfg_div_m1),
        .cfg_hsw(cfg_hsw), .cfg_hbp(cfg_hbp), .cfg_hact(cfg_hact), .cfg_hfp(cfg_hfp),
        .cfg_vsw(cfg_vsw), .cfg_vbp(cfg_vbp), .cfg_vact(cfg_vact), .cfg_vfp(cfg_vfp),
        .cfg_hold(cfg_hold), .int_en(int_en), .int_frame_en(int_frame_en),
        .int_ack(int_ack),
        .hsync(hsync), .vsync(vsync), .de(de), .pix_ce(pix_ce),
        .pix_x(pix_x), .pix_y(pix_y), .int_pend(int_pend), .irq(irq)
    );

    int    total = 0;
    int    bad   = 0;
    string phase = "reset";

    // Reference model state (absolute positions, shadow copy, pending bit).
    bit m_en, m_hsl, m_vsl, m_don, m_pend;
    int m_div, m_hsw, m_hbp, m_hact, m_hfp, m_vsw, m_vbp, m_vact, m_vfp;
    int m_h, m_v, m_dc;

    function automatic int htot();
        return m_hsw + m_hbp + m_hact + m_hfp + 4;
    endfunction

    function automatic int vtot();
        return m_vsw + m_vbp + m_vact + m_vfp + 4;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s (%s) actual=%0d expected=%0d", tag, phase, act, exp);
        end
    endtask

    task automatic model_edge();
        bit tick, fe, load, nrun, fs;
        tick = m_en && (!m_don || m_dc == m_div);
        fe   = tick && (m_h == htot() - 1) && (m_v == vtot() - 1);
        load = !cfg_hold && (!m_en || fe);
        nrun = load ? cfg_en : m_en;
        fs   = nrun && (!m_en || fe);
        if (fs) m_pend = 1;
        else if (int_ack) m_pend = 0;
        if (!m_en || !m_don || m_dc == m_div) m_dc = 0;
        else m_dc++;
        if (!m_en) begin
            m_h = 0; m_v = 0;
        end else if (tick) begin
            if (m_h == htot() - 1) begin
                m_h = 0;
                m_v = (m_v == vtot() - 1) ? 0 : m_v + 1;
            end else begin
                m_h++;
            end
        end
        if (load) begin
            m_en = cfg_en; m_hsl = cfg_hs_low; m_vsl = cfg_vs_low;
            m_don = cfg_div_on; m_div = int'(cfg_div_m1);
            m_hsw = int'(cfg_hsw); m_hbp = int'(cfg_hbp);
            m_hact = int'(cfg_hact); m_hfp = int'(cfg_hfp);
            m_vsw = int'(cfg_vsw); m_vbp = int'(cfg_vbp);
            m_vact = int'(cfg_vact); m_vfp = int'(cfg_vfp);
        end
    endtask

    task automatic compare();
        int  hx0, vy0;
        bit  hs_a, vs_a, e_de, e_ce;
        hx0  = m_hsw + m_hbp + 2;
        vy0  = m_vsw + m_vbp + 2;
        hs_a = m_en && (m_h < m_hsw + 1);
        vs_a = m_en && (m_v < m_vsw + 1);
        e_de = m_en && (m_h >= hx0) && (m_h < hx0 + m_hact + 1)
                    && (m_v >= vy0) && (m_v < vy0 + m_vact + 1);
        e_ce = m_en && (!m_don || m_dc == m_div);
        chk("R1/R5 hsync", int'(hsync), int'(hs_a ^ m_hsl));
        chk("R2/R5 vsync", int'(vsync), int'(vs_a ^ m_vsl));
        chk("R3 de", int'(de), int'(e_de));
        chk("R3 pix_x", int'(pix_x), e_de ? m_h - hx0 : 0);
        chk("R3 pix_y", int'(pix_y), e_de ? m_v - vy0 : 0);
        chk("R4 pix_ce", int'(pix_ce), int'(e_ce));
        chk("R9 int_pend", int'(int_pend), int'(m_pend));
        chk("R9 irq", int'(irq), int'(m_pend && int_en && int_frame_en));
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    task automatic run(input int n, input bit rnd_ack);
        for (int i = 0; i < n; i++) begin
            int_ack = rnd_ack && ($urandom % 24 == 0);
            cyc();
        end
        int_ack = 0;
    endtask

    task automatic rand_cfg();
        cfg_hs_low = 1'($urandom % 2);
        cfg_vs_low = 1'($urandom % 2);
        cfg_div_on = 1'($urandom % 2);
        cfg_div_m1 = DIV_W'($urandom % 4);
        cfg_hsw  = H_W'($urandom % 4);
        cfg_hbp  = H_W'($urandom % 4);
        cfg_hact = H_W'($urandom % 8);
        cfg_hfp  = H_W'($urandom % 4);
        cfg_vsw  = V_W'($urandom % 3);
        cfg_vbp  = V_W'($urandom % 3);
        cfg_vact = V_W'($urandom % 6);
        cfg_vfp  = V_W'($urandom % 3);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #(20 * 190000);
        total++;
        bad++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        // Reset state: R6 idle outputs, pending clear.
        repeat (3) @(negedge clk);
        compare();
        chk("R6 reset de", int'(de), 0);
        @(negedge clk);
        rst_n = 1'b1;

        phase = "R1 R2 R3 fixed timing";
        cfg_hsw = 1; cfg_hbp = 2; cfg_hact = 3; cfg_hfp = 0;
        cfg_vsw = 0; cfg_vbp = 1; cfg_vact = 2; cfg_vfp = 1;
        int_en = 1; int_frame_en = 1; cfg_en = 1;
        run(260, 0);

        phase = "R4 divide by three";
        cfg_div_on = 1; cfg_div_m1 = 2;
        run(900, 0);

        phase = "R5 active-low syncs";
        cfg_hs_low = 1; cfg_vs_low = 1;
        run(900, 0);

        phase = "R7 staged change mid-frame";
        run(37, 0);
        cfg_hact = 6; cfg_vsw = 2; cfg_div_on = 0;
        run(700, 0);

        phase = "R8 hold across frame ends";
        cfg_hold = 1;
        cfg_hsw = 0; cfg_hact = 1; cfg_vact = 0; cfg_hs_low = 0;
        run(500, 0);
        cfg_hold = 0;
        run(400, 0);

        phase = "R10 acknowledge pulses";
        run(1500, 1);

        phase = "R6 disable and re-enable";
        cfg_en = 0;
        run(300, 0);
        cfg_en = 1;
        run(300, 0);

        phase = "R9 pending with enables off";
        int_en = 0;
        run(200, 1);
        int_en = 1; int_frame_en = 0;
        run(200, 1);
        int_frame_en = 1;

        phase = "R1 R4 widest sync and divide";
        cfg_hsw = 63; cfg_hbp = 0; cfg_hact = 0; cfg_hfp = 0;
        cfg_vsw = 0; cfg_vbp = 0; cfg_vact = 0; cfg_vfp = 0;
        cfg_div_on = 1; cfg_div_m1 = 7;
        run(4500, 1);

        phase = "random";
        for (int k = 0; k < 45; k++) begin
            if ($urandom % 3 != 0) rand_cfg();
            cfg_hold = ($urandom % 4 == 0);
            cfg_en   = ($urandom % 6 != 0);
            int_en       = 1'($urandom % 2);
            int_frame_en = ($urandom % 4 != 0);
            run(100 + int'($urandom % 1400), 1);
        end
        cfg_hold = 0;
        run(200, 1);

        summary();
        $finish;
    end
endmodule